// File: doc/BRIEF.md
# Serial Host Command Port with Mode Register and Interrupt

This block is the host-facing control port of a speech storage codec. A host controller selects the port with an active-low select line, clocks bytes in on a serial data line and clocks reply bytes out on a separate line. The port frames the bits into bytes, holds the codec mode register, passes play-page and record-page requests to the storage controller, and drives an interrupt request when the storage controller reports an event.

All logic runs on the local system clock `clk`. The host serial clock, select and data lines are synchronised and edge-detected, so `clk` must run at least four times faster than the host serial clock. In every transfer the first byte after select falls is the command byte, and any bytes that follow are its data. The reply line is three-state at the pad. `host_dout_en` is the output enable, and it is high only while a reply byte is being shifted out. `irq_pull_low` drives an open-drain pull-down, so several peripherals can share one interrupt wire.

Top module: `serial_cmd_port`

## Requirements
- R1: Bits are sampled on the rising edge of `host_sclk` while `host_csn` is low, eight to a byte, most significant bit first. The first complete byte after `host_csn` falls is the command byte.
- R2: Command 10h followed by one data byte loads the mode register from data bits [3:0]: bit0 decode enable (`mode_de`), bit1 powersave (`mode_ps`), bit2 memory size (`mode_ms`), bit3 interrupt enable. All mode bits are 0 after reset. The register changes only when a data byte completes.
- R3: `encode_en` is high exactly when decode enable and powersave are both 0. `decode_en` is high exactly when decode enable is 1 and powersave is 0. The two are never high together.
- R4: Command 62h followed by one data byte gives a one-cycle `play_req` pulse, with `page_num` equal to that data byte. Command 72h does the same on `rec_req`.
- R5: A byte that is incomplete when `host_csn` rises is discarded and has no effect.
- R6: If `host_csn` rises after a command byte but before its data byte, the command is abandoned. The next transfer again treats its first byte as a command.
- R7: `host_dout_en` is low except during the eight bit periods of a reply byte. It falls at the falling serial clock edge after the last reply bit, or when `host_csn` rises.
- R8: Command 7Fh returns the mode register as {0000, bits[3:0]} in the byte that follows. Reply bits change on falling `host_sclk` edges, most significant bit first.
- R9: A high `ctrl_event` sets the pending flag. `irq_pull_low` is high when the flag is set and interrupt enable is 1.
- R10: Command 7Eh returns the status byte {pending, 000, mode bits[3:0]} and clears the pending flag, which releases `irq_pull_low`. An event in the same cycle as the clear wins.
- R11: Data bytes after the first one in a transfer, and data bytes that follow an unknown command, change nothing.
- R12: After reset `host_dout_en`, `irq_pull_low`, `play_req` and `rec_req` are low and `encode_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sclk | input | 1 | Host serial clock |
| host_csn | input | 1 | Host select, active low |
| host_din | input | 1 | Serial command and data from the host |
| host_dout | output | 1 | Serial reply bit to the host |
| host_dout_en | output | 1 | Output enable of the three-state reply pad |
| irq_pull_low | output | 1 | Open-drain interrupt pull-down enable |
| ctrl_event | input | 1 | Event pulse from the storage controller |
| mode_de | output | 1 | Decode enable mode bit |
| mode_ps | output | 1 | Powersave mode bit |
| mode_ms | output | 1 | Memory size mode bit |
| encode_en | output | 1 | Encoder active |
| decode_en | output | 1 | Decoder active |
| play_req | output | 1 | One-cycle play-page request |
| rec_req | output | 1 | One-cycle record-page request |
| page_num | output | PAGE_W | Page of the latest request |

## Verification
The mode register is written with directed values and with random bytes, then read back through the reply command. This separates bit-order faults and field-position faults from plain storage faults. Transfers are cut at several points: partway through a byte, right after a command, and with extra trailing bytes. These show whether framing resets on select and whether data bytes are counted correctly. Event sequences with interrupt enable on and off, each followed by two status reads, separate how the pending flag is set, how it is masked and how a read clears it.

// File: rtl/scp_pkg.sv
package scp_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t CMD_MODE_WR = 8'h10;
    localparam byte_t CMD_PLAY    = 8'h62;
    localparam byte_t CMD_REC     = 8'h72;
    localparam byte_t CMD_STAT_RD = 8'h7E;
    localparam byte_t CMD_MODE_RD = 8'h7F;

    typedef struct packed {
        logic ie;
        logic ms;
        logic ps;
        logic de;
    } mode_t;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic csn,
    input  logic din,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic csn_s,
    output logic din_s
);
    typedef struct packed {
        logic [STAGES:0]   sck;
        logic [STAGES-1:0] cs;
        logic [STAGES-1:0] dt;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.sck = (st_q.sck << 1) | (STAGES+1)'(sclk);
        st_d.cs  = (st_q.cs << 1) | STAGES'(csn);
        st_d.dt  = (st_q.dt << 1) | STAGES'(din);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sck <= '0;
            st_q.cs  <= '1;
            st_q.dt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk_rise = st_q.sck[STAGES-1] & ~st_q.sck[STAGES];
    assign sclk_fall = ~st_q.sck[STAGES-1] & st_q.sck[STAGES];
    assign csn_s     = st_q.cs[STAGES-1];
    assign din_s     = st_q.dt[STAGES-1];
endmodule

// File: rtl/scp_rx.sv
module scp_rx
    import scp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sclk_rise,
    input  logic  csn_s,
    input  logic  din_s,
    output logic  byte_valid,
    output byte_t byte_data,
    output logic  byte_is_cmd
);
    localparam int CNT_W = $clog2(BYTE_W);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        byte_t            sr;
        logic             first;
        logic             valid;
        byte_t            data;
        logic             is_cmd;
    } rx_t;

    rx_t rx_d, rx_q;
    byte_t shifted;

    always_comb begin
        rx_d       = rx_q;
        rx_d.valid = 1'b0;
        shifted    = {rx_q.sr[BYTE_W-2:0], din_s};
        if (csn_s) begin
            rx_d.cnt   = '0;
            rx_d.first = 1'b1;
        end else if (sclk_rise) begin
            rx_d.sr = shifted;
            if (rx_q.cnt == CNT_W'(BYTE_W-1)) begin
                rx_d.cnt    = '0;
                rx_d.valid  = 1'b1;
                rx_d.data   = shifted;
                rx_d.is_cmd = rx_q.first;
                rx_d.first  = 1'b0;
            end else begin
                rx_d.cnt = rx_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q       <= '0;
            rx_q.first <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign byte_valid  = rx_q.valid;
    assign byte_data   = rx_q.data;
    assign byte_is_cmd = rx_q.is_cmd;
endmodule

// File: rtl/scp_reply.sv
module scp_reply
    import scp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  byte_t load_data,
    input  logic  sclk_fall,
    input  logic  csn_s,
    output logic  reply_bit,
    output logic  reply_en
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    typedef struct packed {
        byte_t            sr;
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             en;
        logic             bit_out;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (csn_s) begin
            tx_d.armed = 1'b0;
            tx_d.en    = 1'b0;
        end else if (load) begin
            tx_d.sr    = load_data;
            tx_d.cnt   = '0;
            tx_d.armed = 1'b1;
            tx_d.en    = 1'b0;
        end else if (sclk_fall && tx_q.armed) begin
            if (tx_q.cnt < CNT_W'(BYTE_W)) begin
                tx_d.bit_out = tx_q.sr[BYTE_W-1];
                tx_d.sr      = tx_q.sr << 1;
                tx_d.cnt     = tx_q.cnt + 1'b1;
                tx_d.en      = 1'b1;
            end else begin
                tx_d.armed = 1'b0;
                tx_d.en    = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign reply_bit = tx_q.bit_out;
    assign reply_en  = tx_q.en;
endmodule

// File: rtl/serial_cmd_port.sv
module serial_cmd_port
    import scp_pkg::*;
#(
    parameter int PAGE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sclk,
    input  logic              host_csn,
    input  logic              host_din,
    output logic              host_dout,
    output logic              host_dout_en,
    output logic              irq_pull_low,
    input  logic              ctrl_event,
    output logic              mode_de,
    output logic              mode_ps,
    output logic              mode_ms,
    output logic              encode_en,
    output logic              decode_en,
    output logic              play_req,
    output logic              rec_req,
    output logic [PAGE_W-1:0] page_num
);
    localparam int MODE_W = $bits(mode_t);
    localparam int PAD_W  = BYTE_W - MODE_W - 1;

    logic  sclk_rise, sclk_fall, csn_s, din_s;
    logic  rx_valid, rx_is_cmd;
    byte_t rx_byte;
    logic  rep_load;
    byte_t rep_val;

    typedef struct packed {
        byte_t             cmd;
        logic              data_taken;
        mode_t             mode;
        logic              pending;
        logic              play;
        logic              rec;
        logic [PAGE_W-1:0] page;
    } ctl_t;

    ctl_t state_d, state_q;

    scp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (host_sclk),
        .csn       (host_csn),
        .din       (host_din),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .csn_s     (csn_s),
        .din_s     (din_s)
    );

    scp_rx u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_rise   (sclk_rise),
        .csn_s       (csn_s),
        .din_s       (din_s),
        .byte_valid  (rx_valid),
        .byte_data   (rx_byte),
        .byte_is_cmd (rx_is_cmd)
    );

    scp_reply u_reply (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (rep_load),
        .load_data (rep_val),
        .sclk_fall (sclk_fall),
        .csn_s     (csn_s),
        .reply_bit (host_dout),
        .reply_en  (host_dout_en)
    );

    always_comb begin
        state_d      = state_q;
        state_d.play = 1'b0;
        state_d.rec  = 1'b0;
        rep_load     = 1'b0;
        rep_val      = '0;
        if (rx_valid) begin
            if (rx_is_cmd) begin
                state_d.cmd        = rx_byte;
                state_d.data_taken = 1'b0;
                if (rx_byte == CMD_STAT_RD) begin
                    rep_load        = 1'b1;
                    rep_val         = {state_q.pending, {PAD_W{1'b0}}, state_q.mode};
                    state_d.pending = 1'b0;
                end else if (rx_byte == CMD_MODE_RD) begin
                    rep_load = 1'b1;
                    rep_val  = {1'b0, {PAD_W{1'b0}}, state_q.mode};
                end
            end else if (!state_q.data_taken) begin
                state_d.data_taken = 1'b1;
                case (state_q.cmd)
                    CMD_MODE_WR: state_d.mode = mode_t'(rx_byte[MODE_W-1:0]);
                    CMD_PLAY: begin
                        state_d.play = 1'b1;
                        state_d.page = rx_byte[PAGE_W-1:0];
                    end
                    CMD_REC: begin
                        state_d.rec  = 1'b1;
                        state_d.page = rx_byte[PAGE_W-1:0];
                    end
                    default: ;
                endcase
            end
        end
        if (ctrl_event) state_d.pending = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign mode_de      = state_q.mode.de;
    assign mode_ps      = state_q.mode.ps;
    assign mode_ms      = state_q.mode.ms;
    assign encode_en    = ~state_q.mode.de & ~state_q.mode.ps;
    assign decode_en    = state_q.mode.de & ~state_q.mode.ps;
    assign irq_pull_low = state_q.pending & state_q.mode.ie;
    assign play_req     = state_q.play;
    assign rec_req      = state_q.rec;
    assign page_num     = state_q.page;
endmodule

// File: rtl/scp_checker.sv
module scp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       csn_s,
    input logic       reply_en,
    input logic       byte_valid,
    input logic [3:0] mode_bits,
    input logic       pending,
    input logic       ctrl_event,
    input logic       play_req,
    input logic       rec_req,
    input logic       encode_en,
    input logic       decode_en
);
    AST_REPLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        reply_en |-> !csn_s); // R7
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |=> $stable(mode_bits)); // R2
    AST_ENC_DEC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(encode_en && decode_en)); // R3
    AST_PLAY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        play_req |=> !play_req); // R4
    AST_REQ_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (play_req || rec_req) |-> $past(byte_valid)); // R4
    AST_EVENT_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_event |=> pending); // R9
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> $past(byte_valid)); // R10
endmodule

bind serial_cmd_port scp_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .csn_s      (csn_s),
    .reply_en   (host_dout_en),
    .byte_valid (rx_valid),
    .mode_bits  (state_q.mode),
    .pending    (state_q.pending),
    .ctrl_event (ctrl_event),
    .play_req   (play_req),
    .rec_req    (rec_req),
    .encode_en  (encode_en),
    .decode_en  (decode_en)
);

// File: tb/tb_serial_cmd_port.sv
`timescale 1ns/1ps
module tb_serial_cmd_port;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8 * CLK_PERIOD;

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_sclk = 1'b0, host_csn = 1'b1, host_din = 1'b0, ctrl_event = 1'b0;
    logic host_dout, host_dout_en, irq_pull_low;
    logic mode_de, mode_ps, mode_ms, encode_en, decode_en, play_req, rec_req;
    logic [7:0] page_num;

    int errors = 0, checks = 0;
    int play_cnt = 0, rec_cnt = 0;
    logic [7:0] last_page = '0;
    logic [3:0] exp_mode = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_cmd_port dut (
        .clk(clk), .rst_n(rst_n), .host_sclk(host_sclk), .host_csn(host_csn),
        .host_din(host_din), .host_dout(host_dout), .host_dout_en(host_dout_en),
        .irq_pull_low(irq_pull_low), .ctrl_event(ctrl_event), .mode_de(mode_de),
        .mode_ps(mode_ps), .mode_ms(mode_ms), .encode_en(encode_en),
        .decode_en(decode_en), .play_req(play_req), .rec_req(rec_req),
        .page_num(page_num)
    );

    always @(negedge clk) begin
        if (play_req) begin play_cnt++; last_page = page_num; end
        if (rec_req)  begin rec_cnt++;  last_page = page_num; end
    end

    function automatic logic [3:0] mode_port_bits();
        return {1'b0, mode_ms, mode_ps, mode_de};
    endfunction

    function automatic logic [1:0] exp_encdec(input logic [3:0] m);
        return {!m[0] && !m[1], m[0] && !m[1]};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cs_begin();
        host_csn = 1'b0;
        #(HALF);
    endtask

    task automatic cs_end();
        host_sclk = 1'b0;
        #(HALF);
        host_csn = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n,
                             output logic [7:0] got, output int en_cnt);
        got = '0;
        en_cnt = 0;
        for (int i = 0; i < n; i++) begin
            host_sclk = 1'b0;
            host_din  = b[7-i];
            #(HALF);
            got[7-i] = host_dout;
            if (host_dout_en) en_cnt++;
            host_sclk = 1'b1;
            #(HALF);
        end
    endtask

    task automatic write_cmd(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] g;
        int e;
        cs_begin();
        send_bits(c, 8, g, e);
        send_bits(d, 8, g, e);
        cs_end();
    endtask

    task automatic read_cmd(input logic [7:0] c, output logic [7:0] got,
                            output int en_cmd, output int en_rep);
        cs_begin();
        send_bits(c, 8, got, en_cmd);
        send_bits(8'h00, 8, got, en_rep);
        cs_end();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] got, g;
        int ec, er, e;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R12 reset state
        chk(!host_dout_en && !irq_pull_low && !play_req && !rec_req && encode_en && !decode_en,
            "R12 reset outputs", {host_dout_en, irq_pull_low, play_req, rec_req, encode_en, decode_en}, 6'b000010);
        chk(mode_port_bits() == 4'h0, "R2 reset mode", mode_port_bits(), 0);

        // R1 R2 R3 mode write, MSB first
        write_cmd(8'h10, 8'h05);
        exp_mode = 4'h5;
        chk(mode_port_bits() == 4'h5, "R1 R2 mode write 05", mode_port_bits(), 5);
        chk({encode_en, decode_en} == exp_encdec(exp_mode), "R3 decode select",
            {encode_en, decode_en}, exp_encdec(exp_mode));

        // R8 R7 mode readback
        read_cmd(8'h7F, got, ec, er);
        chk(got == 8'h05, "R8 mode read value", got, 8'h05);
        chk(ec == 0 && er == 8, "R7 reply enable window", ec * 16 + er, 8);
        chk(!host_dout_en, "R7 enable low after frame", host_dout_en, 0);

        // R3 powersave
        write_cmd(8'h10, 8'h03);
        exp_mode = 4'h3;
        chk({encode_en, decode_en} == 2'b00 && mode_ps, "R3 powersave off",
            {mode_ps, encode_en, decode_en}, 3'b100);

        // R5 incomplete data byte
        cs_begin();
        send_bits(8'h10, 8, g, e);
        send_bits(8'h0F, 5, g, e);
        cs_end();
        chk(mode_port_bits() == 4'h3, "R5 partial byte discarded", mode_port_bits(), 3);

        // R6 abort after command, next frame starts with command
        cs_begin();
        send_bits(8'h10, 8, g, e);
        cs_end();
        write_cmd(8'h62, 8'h2A);
        chk(mode_port_bits() == 4'h3, "R6 abort keeps mode", mode_port_bits(), 3);
        chk(play_cnt == 1 && last_page == 8'h2A, "R6 R4 play after abort", last_page, 8'h2A);

        // R4 record
        write_cmd(8'h72, 8'h11);
        chk(rec_cnt == 1 && play_cnt == 1 && last_page == 8'h11, "R4 record page",
            {rec_cnt[3:0], last_page}, 12'h111);

        // R11 extra bytes and unknown command
        cs_begin();
        send_bits(8'h10, 8, g, e);
        send_bits(8'h08, 8, g, e);
        send_bits(8'h0F, 8, g, e);
        cs_end();
        exp_mode = 4'h8;
        read_cmd(8'h7F, got, ec, er);
        chk(got == 8'h08, "R11 extra data ignored", got, 8'h08);
        write_cmd(8'h33, 8'h0F);
        read_cmd(8'h7F, got, ec, er);
        chk(got == 8'h08, "R11 unknown command ignored", got, 8'h08);

        // R9 R10 interrupt with enable
        @(negedge clk); ctrl_event = 1'b1;
        @(negedge clk); ctrl_event = 1'b0;
        @(negedge clk);
        chk(irq_pull_low, "R9 irq asserted", irq_pull_low, 1);
        read_cmd(8'h7E, got, ec, er);
        chk(got == 8'h88, "R10 status with pending", got, 8'h88);
        chk(!irq_pull_low, "R10 irq released", irq_pull_low, 0);
        read_cmd(8'h7E, got, ec, er);
        chk(got == 8'h08, "R10 status cleared", got, 8'h08);

        // R9 masked
        write_cmd(8'h10, 8'h00);
        exp_mode = 4'h0;
        @(negedge clk); ctrl_event = 1'b1;
        @(negedge clk); ctrl_event = 1'b0;
        @(negedge clk);
        chk(!irq_pull_low, "R9 irq masked", irq_pull_low, 0);
        read_cmd(8'h7E, got, ec, er);
        chk(got == 8'h80, "R9 pending while masked", got, 8'h80);

        // random mode writes and play pages
        for (int k = 0; k < 16; k++) begin
            logic [7:0] r;
            r = 8'($urandom);
            write_cmd(8'h10, r);
            exp_mode = r[3:0];
            read_cmd(8'h7F, got, ec, er);
            chk(got == {4'h0, exp_mode}, "R2 R8 random mode", got, {4'h0, exp_mode});
            chk({encode_en, decode_en} == exp_encdec(exp_mode), "R3 random decode",
                {encode_en, decode_en}, exp_encdec(exp_mode));
            r = 8'($urandom);
            write_cmd(8'h62, r);
            chk(last_page == r && play_cnt == k + 2, "R4 random play", last_page, r);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule